// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

This block is the shift unit of a 32-bit integer datapath. In one combinational pass it shifts an operand left logically, right logically or right arithmetically by a 6-bit count. It produces the shifted value together with a carry, an extend, a negative and a zero flag. The count is used at its full range of 0 to 63 and is never folded modulo the data width. A count of zero, a count equal to the width and counts beyond the width each give their own result and carry.

The carry is the last bit pushed out of the operand. With a zero count nothing is pushed out, so the carry input from the flag register passes straight to the carry output. The extend flag always copies the carry, which lets multi-word sequences use it directly. The surrounding pipeline registers the inputs and outputs. The block holds no state.

Top module: `shf_cc_shifter`

## Requirements
- R1: When `count_i` is 0, `result_o` equals `opnd_i` and `carry_o` equals `carry_i`, for every kind.
- R2: Left shift by n, 1 ≤ n ≤ 31, gives `result_o` = `opnd_i` << n with zeros filled in, and `carry_o` = `opnd_i` bit (32 − n).
- R3: Right shift by n, 1 ≤ n ≤ 31, gives `carry_o` = `opnd_i` bit (n − 1). A logical right shift fills the vacated high bits with zeros, and an arithmetic right shift fills them with `opnd_i` bit 31.
- R4: A logical shift by exactly 32 gives a zero result. The carry is `opnd_i` bit 0 for a left shift and `opnd_i` bit 31 for a right shift.
- R5: A logical shift, left or right, by 33 to 63 gives a zero result and a zero carry.
- R6: An arithmetic right shift by 32 to 63 sets every result bit and the carry to `opnd_i` bit 31.
- R7: `extend_o` equals `carry_o` for every kind and count, including a zero count.
- R8: `neg_o` equals `result_o` bit 31. `zero_o` is 1 exactly when `result_o` is all zeros.
- R9: `kind_i` is decoded as follows:
  - 2'b00 selects a left shift.
  - 2'b01 also selects a left shift, because bit 0 is ignored when bit 1 is 0.
  - 2'b10 selects a logical right shift.
  - 2'b11 selects an arithmetic right shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to shift |
| count_i | input | 6 | Shift count, 0 to 63, not folded |
| kind_i | input | 2 | Shift kind: bit 1 = right, bit 0 = arithmetic (right only) |
| carry_i | input | 1 | Current carry flag, passed through on a zero count |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Last bit shifted out, or `carry_i` on a zero count |
| extend_o | output | 1 | Extend flag, equal to `carry_o` |
| neg_o | output | 1 | Result bit 31 |
| zero_o | output | 1 | Result is all zeros |

## Verification
The carry pass-through and the zero-flag generation can happen on the same operation. With a zero count and a zero operand, the result is zero and Z must be set, while the carry and the extend flag must follow `carry_i` rather than any shifted bit. The bench provokes this with both values of `carry_i` and with each kind. The same collision occurs at the width boundary: a logical shift by exactly 32 gives a zero result, yet the carry must still report a real operand bit. The bench uses operands whose end bits differ, so that a carry taken from the wrong side, or forced to zero, is visible next to a correct Z.

// File: rtl/shf_pkg.sv
package shf_pkg;

  // Shift kind: bit 1 picks the right direction, bit 0 picks sign fill (right only)
  typedef enum logic [1:0] {
    SHF_LSL     = 2'b00,
    SHF_LSL_ALT = 2'b01,
    SHF_LSR     = 2'b10,
    SHF_ASR     = 2'b11
  } shf_kind_e;

  function automatic logic kind_is_right(input logic [1:0] k);
    return k[1];
  endfunction

  function automatic logic kind_is_arith(input logic [1:0] k);
    return k[1] & k[0];
  endfunction

endpackage

// File: rtl/shf_reverse.sv
module shf_reverse #(
  parameter int W = 32
) (
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign dout_o[b] = din_i[W-1-b];
  end

endmodule

// File: rtl/shf_barrel.sv
// Right-shifting log barrel over a window {fill x W, data, guard}.
// After the shift, bits [W:1] hold the result and bit 0 holds the last bit out.
module shf_barrel #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              fill_i,
  input  logic [CNT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] res_o,
  output logic              last_o
);

  localparam int WIN_W = 2 * DATA_W + 1;

  logic [WIN_W-1:0] stg [0:CNT_W];

  assign stg[0] = {{DATA_W{fill_i}}, data_i, 1'b0};

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [WIN_W-1:0] moved;
    assign moved      = {{SH{fill_i}}, stg[k][WIN_W-1:SH]};
    assign stg[k+1]   = amt_i[k] ? moved : stg[k];
  end

  assign res_o  = stg[CNT_W][DATA_W:1];
  assign last_o = stg[CNT_W][0];

endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] core_res_i,
  input  logic              core_out_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              extend_o,
  output logic              neg_o,
  output logic              zero_o
);

  logic no_shift;

  always_comb begin
    no_shift = (count_i == '0);
    if (no_shift) begin
      result_o = opnd_i;
      carry_o  = carry_i;
    end else begin
      result_o = core_res_i;
      carry_o  = core_out_i;
    end
    extend_o = carry_o;
    neg_o    = result_o[DATA_W-1];
    zero_o   = ~|result_o;
  end

endmodule

// File: rtl/shf_cc_shifter.sv
module shf_cc_shifter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [1:0]        kind_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              extend_o,
  output logic              neg_o,
  output logic              zero_o
);

  import shf_pkg::*;

  logic              go_right;
  logic              fill_bit;
  logic [DATA_W-1:0] opnd_rev;
  logic [DATA_W-1:0] core_in;
  logic [DATA_W-1:0] core_res;
  logic [DATA_W-1:0] core_res_rev;
  logic [DATA_W-1:0] core_final;
  logic              core_out;

  assign go_right = kind_is_right(kind_i);
  assign fill_bit = kind_is_arith(kind_i) & opnd_i[DATA_W-1];

  // A left shift runs through the right barrel with the bits mirrored
  shf_reverse #(.W(DATA_W)) rev_in_i (
    .din_i  (opnd_i),
    .dout_o (opnd_rev)
  );

  assign core_in = go_right ? opnd_i : opnd_rev;

  shf_barrel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) barrel_i (
    .data_i (core_in),
    .fill_i (fill_bit),
    .amt_i  (count_i),
    .res_o  (core_res),
    .last_o (core_out)
  );

  shf_reverse #(.W(DATA_W)) rev_out_i (
    .din_i  (core_res),
    .dout_o (core_res_rev)
  );

  assign core_final = go_right ? core_res : core_res_rev;

  shf_flags #(.DATA_W(DATA_W), .CNT_W(CNT_W)) flags_i (
    .opnd_i     (opnd_i),
    .count_i    (count_i),
    .carry_i    (carry_i),
    .core_res_i (core_final),
    .core_out_i (core_out),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .extend_o   (extend_o),
    .neg_o      (neg_o),
    .zero_o     (zero_o)
  );

endmodule

// File: rtl/shf_cc_shifter_chk.sv
module shf_cc_shifter_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input logic [DATA_W-1:0] opnd_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [1:0]        kind_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              extend_o,
  input logic              neg_o,
  input logic              zero_o
);

  localparam logic [CNT_W:0] WIDTH_C = (CNT_W+1)'(DATA_W);

  logic [DATA_W-1:0] left_pick;
  logic [DATA_W-1:0] right_pick;
  logic [CNT_W:0]    cnt_ext;
  logic              sgn;

  assign cnt_ext    = {1'b0, count_i};
  assign left_pick  = opnd_i >> (WIDTH_C - cnt_ext);
  assign right_pick = opnd_i >> (count_i - 1'b1);
  assign sgn        = opnd_i[DATA_W-1];

  always_comb begin
    AST_ZERO_COUNT_PASS: assert (count_i != '0 || (result_o == opnd_i && carry_o == carry_i))
      else $error("zero count pass-through"); // R1
    AST_LEFT_CARRY: assert (kind_i[1] || count_i == '0 || cnt_ext >= WIDTH_C || carry_o == left_pick[0])
      else $error("left carry"); // R2
    AST_RIGHT_CARRY: assert (!kind_i[1] || count_i == '0 || cnt_ext >= WIDTH_C || carry_o == right_pick[0])
      else $error("right carry"); // R3
    AST_WIDTH_ZERO: assert ((kind_i == 2'b11) || cnt_ext != WIDTH_C || result_o == '0)
      else $error("logical shift by width"); // R4
    AST_LOGIC_FAR: assert ((kind_i == 2'b11) || cnt_ext <= WIDTH_C || (result_o == '0 && !carry_o))
      else $error("logical far shift"); // R5
    AST_ARITH_FAR: assert (kind_i != 2'b11 || cnt_ext < WIDTH_C || (result_o == {DATA_W{sgn}} && carry_o == sgn))
      else $error("arithmetic far shift"); // R6
    AST_EXTEND_COPY: assert (extend_o == carry_o)
      else $error("extend copy"); // R7
    AST_NZ_FLAGS: assert (neg_o == result_o[DATA_W-1] && zero_o == (result_o == '0))
      else $error("N and Z flags"); // R8
  end

endmodule

bind shf_cc_shifter shf_cc_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/shf_cc_shifter_tb_top.sv
module shf_cc_shifter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic [31:0] opnd;
  logic [5:0]  cnt;
  logic [1:0]  kind;
  logic        cin;
  logic [31:0] res;
  logic        c_o, x_o, n_o, z_o;

  int checks   = 0;
  int failures = 0;

  shf_cc_shifter dut_i (
    .opnd_i   (opnd),
    .count_i  (cnt),
    .kind_i   (kind),
    .carry_i  (cin),
    .result_o (res),
    .carry_o  (c_o),
    .extend_o (x_o),
    .neg_o    (n_o),
    .zero_o   (z_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Stimulus table: {operand, carry in}
  localparam logic [32:0] STIM [0:7] = '{
    {32'h0000_0000, 1'b1},
    {32'hFFFF_FFFF, 1'b0},
    {32'h8000_0001, 1'b1},
    {32'h7FFF_FFFE, 1'b0},
    {32'hA5A5_5A5A, 1'b1},
    {32'h0000_0001, 1'b0},
    {32'h8000_0000, 1'b1},
    {32'h1234_5678, 1'b0}
  };
  localparam logic [5:0] CNTS [0:5] = '{6'd0, 6'd1, 6'd31, 6'd32, 6'd33, 6'd63};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%h cnt=%0d kind=%b cin=%b actual=%h expected=%h",
               tag, opnd, cnt, kind, cin, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic ref_model(input logic [31:0] op, input int n, input logic [1:0] k, input logic ci,
                           output logic [31:0] r, output logic c);
    if (n == 0) begin
      r = op; c = ci;
    end else if (!k[1]) begin
      if (n < 32)       begin r = op << n; c = op[32-n]; end
      else if (n == 32) begin r = '0; c = op[0]; end
      else              begin r = '0; c = 1'b0; end
    end else if (!k[0]) begin
      if (n < 32)       begin r = op >> n; c = op[n-1]; end
      else if (n == 32) begin r = '0; c = op[31]; end
      else              begin r = '0; c = 1'b0; end
    end else begin
      if (n < 32) begin r = 32'($signed(op) >>> n); c = op[n-1]; end
      else        begin r = {32{op[31]}}; c = op[31]; end
    end
  endtask

  function automatic string tag_for(input int n, input logic [1:0] k);
    if (n == 0) return "R1";
    if (n < 32) return k[1] ? "R3" : "R2";
    if (k == 2'b11) return "R6";
    if (n == 32) return "R4";
    return "R5";
  endfunction

  task automatic apply(input logic [31:0] op, input logic [5:0] n, input logic [1:0] k, input logic ci);
    @(negedge clk);
    opnd = op; cnt = n; kind = k; cin = ci;
    #1;
  endtask

  task automatic full_check(input string tag);
    logic [31:0] er;
    logic        ec;
    ref_model(opnd, int'(cnt), kind, cin, er, ec);
    chk(tag, res, er);
    chk(tag, {31'b0, c_o}, {31'b0, ec});
    chk("R7", {31'b0, x_o}, {31'b0, ec});
    chk("R8_neg", {31'b0, n_o}, {31'b0, er[31]});
    chk("R8_zero", {31'b0, z_o}, {31'b0, (er == 32'h0)});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    opnd = '0; cnt = '0; kind = 2'b00; cin = 1'b0;
    repeat (2) @(posedge clk);
    // Idle state: all-zero inputs
    apply(32'h0, 6'd0, 2'b00, 1'b0);
    chk("R1_idle", res, 32'h0);
    chk("R8_idle", {31'b0, z_o}, 32'h1);

    // Table walk: every kind (including 2'b01) at the boundary counts
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 6; j++) begin
        for (int k = 0; k < 4; k++) begin
          apply(STIM[i][32:1], CNTS[j], 2'(k), STIM[i][0]);
          full_check(tag_for(int'(CNTS[j]), 2'(k)));
        end
      end
    end

    // Directed corner cases with hand-computed values
    apply(32'h8000_0001, 6'd1, 2'b00, 1'b0);
    chk("R2", res, 32'h0000_0002); chk("R2", {31'b0, c_o}, 32'h1);
    apply(32'h0000_0003, 6'd1, 2'b10, 1'b0);
    chk("R3", res, 32'h0000_0001); chk("R3", {31'b0, c_o}, 32'h1);
    apply(32'h8000_0000, 6'd4, 2'b11, 1'b1);
    chk("R3", res, 32'hF800_0000); chk("R3", {31'b0, c_o}, 32'h0);
    apply(32'h0000_0001, 6'd32, 2'b00, 1'b0);
    chk("R4", res, 32'h0); chk("R4", {31'b0, c_o}, 32'h1);
    apply(32'h8000_0000, 6'd32, 2'b10, 1'b0);
    chk("R4", res, 32'h0); chk("R4", {31'b0, c_o}, 32'h1);
    apply(32'hFFFF_FFFF, 6'd40, 2'b10, 1'b1);
    chk("R5", res, 32'h0); chk("R5", {31'b0, c_o}, 32'h0);
    apply(32'h8000_0000, 6'd63, 2'b11, 1'b0);
    chk("R6", res, 32'hFFFF_FFFF); chk("R6", {31'b0, c_o}, 32'h1);
    apply(32'h0, 6'd0, 2'b11, 1'b1);
    chk("R1", {31'b0, c_o}, 32'h1); chk("R7", {31'b0, x_o}, 32'h1);
    chk("R8", {31'b0, z_o}, 32'h1);
    apply(32'h4000_0001, 6'd1, 2'b01, 1'b0);
    chk("R9", res, 32'h8000_0002); chk("R9", {31'b0, n_o}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule